// File: doc/BRIEF.md
# I2C Slave Engine with Clock Stretching

This block is the target side of a two-wire serial bus. It samples the clock and data lines through synchronisers and finds START, repeated START and STOP. It then compares the first byte after a START with a programmed own address of either 7 or 10 bits. On a match it either receives bytes into a holding output or sends bytes taken from an input. Both bus lines are open-drain. The block only ever pulls a line low, through the `scl_oe` and `sda_oe` outputs.

Software controls the block through one 16-bit control word that it writes in a single cycle and can read back at any time. The word enables the engine and sets the width of the address. It also enables the general call address, turns on an accept-all mode, and selects whether clock stretching is under full software control or only starts automatically. Three further bits are only stored. A single-cycle interrupt pulse asks software to act: after a match, after each received byte, and each time a byte to send is needed.

Top module: `i2c_stretch_slave`

## Requirements
- R1: When control bit 0 (enable) is 0 the block pulls neither line low, acknowledges nothing and raises no interrupt, whatever happens on the bus.
- R2: Control bit 1 (clock release) resets to 1. While the block is enabled and this bit is 0, `scl_oe` is 1 and SCL is held low. While it is 1, SCL is not driven.
- R3: With control bit 2 (stretch enable) at 1, a write sets the release bit to the written value. Hardware also clears the release bit when a transmitted byte is about to start and at the end of the acknowledge of every received data byte.
- R4: With stretch enable at 0, a written 0 leaves the release bit unchanged and only a written 1 takes effect. Hardware clears the release bit only when a transmitted byte is about to start. Received bytes never cause a stretch in this setting.
- R5: With control bit 3 (accept-all) at 1, every address byte is acknowledged whatever the own address is.
- R6: Control bit 4 selects the address width: 0 for 7 bits (`own_addr[6:0]` against byte bits 7:1), 1 for 10 bits. In 10-bit mode the first byte is 11110, then `own_addr[9:8]`, then R/W, and the second byte must equal `own_addr[7:0]`. After a full 10-bit match, a repeated START followed by the first byte with R/W = 1 enters transmit. That first byte with R/W = 1 is refused if no full match has happened since the last STOP.
- R7: With control bit 5 (general call) at 1, the byte 0x00 is acknowledged and raises the interrupt. With it at 0, 0x00 is not acknowledged unless it matches for another reason.
- R8: The control word resets to 0x0002. Bits 8:6 are stored and read back with no effect. Bits 15:9 always read 0.
- R9: `irq` is high for exactly one clock for each completed address match, each received data byte and each request for a byte to transmit.
- R10: In receive, each data byte is acknowledged and appears on `rx_data` (MSB first on the bus) by the end of its acknowledge clock.
- R11: In transmit, the byte on `tx_data` is shifted out MSB first, with data changing only while SCL is low. A master acknowledge asks for another byte. A master not-acknowledge ends the transfer.
- R12: While the block holds SCL low, its bit count does not advance. After release, the next byte is received in full and correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word to write |
| ctrl_rdata | output | 16 | Current control word |
| own_addr | input | 10 | Own bus address; bits 6:0 are used in 7-bit mode |
| rx_data | output | 8 | Last byte received |
| tx_data | input | 8 | Next byte to transmit |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench plays an open-drain bus master that honours stretching. It targets the release-bit rules first. If a written 0 were not ignored with stretching off, SCL would stay held. If the clear after a received byte were applied in that mode, the master would stall after every byte. If the clear at the start of transmit were missing, the first read bit would carry stale data. Addressing corner cases follow:
- a 10-bit header with the wrong high bits;
- a read header sent without an earlier full match;
- the general call address with the feature off;
- accept-all mode.

A wrong decode on any of these shows up as an acknowledge that is wrong in one direction or the other. The bench also checks that a byte sent after a long stretch arrives whole. A counter that moved during the stretch would shift the byte by one or more bits.

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          ctrl_we,
  input  logic [15:0]   ctrl_wdata,
  output logic [15:0]   ctrl_rdata,
  input  logic [AW-1:0] own_addr,
  output logic [7:0]    rx_data,
  input  logic [7:0]    tx_data,
  output logic          irq
);
  typedef enum logic [2:0] {IDLE, ADR1, ADR2, RXD, TXD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       en, rel, stren, prom, a10, gcen;
  logic [2:0] spare;
  st_t        st, nxt;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       sda_drv, m10;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire rise  = scl_s & ~scl_q;
  wire fall  = ~scl_s & scl_q;
  wire start = scl_s & scl_q & sda_q & ~sda_s;
  wire stop  = scl_s & scl_q & ~sda_q & sda_s;

  wire rw      = sh[0];
  wire hdr     = sh[7:3] == 5'b11110;
  wire m7      = ~a10 & (sh[7:1] == own_addr[6:0]);
  wire h10     = a10 & hdr & (sh[2:1] == own_addr[AW-1:AW-2]);
  wire gc      = gcen & (sh == 8'h00);
  wire ack1    = rw ? (m7 | (h10 & m10) | prom) : (gc | m7 | h10 | prom);
  wire to_adr2 = ~rw & a10 & hdr & (h10 | prom);
  wire ack2    = prom | (sh == own_addr[7:0]);
  wire active  = en & ~start & ~stop & (st != IDLE);
  wire hw_clr  = active & fall & (cnt == 4'd9) &
                 ((nxt == TXD) | ((st == RXD) & stren));

  assign scl_oe     = en & ~rel;
  assign sda_oe     = en & sda_drv;
  assign ctrl_rdata = {7'b0, spare, gcen, a10, prom, stren, rel, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {spare, gcen, a10, prom, stren, en} <= '0;
      rel <= 1'b1;
    end else begin
      if (ctrl_we) begin
        {spare, gcen, a10, prom} <= ctrl_wdata[8:3];
        stren <= ctrl_wdata[2];
        en    <= ctrl_wdata[0];
        rel   <= stren ? ctrl_wdata[1] : (rel | ctrl_wdata[1]);
      end else if (hw_clr) begin
        rel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; nxt <= IDLE; cnt <= '0; sh <= '0;
      sda_drv <= 1'b0; m10 <= 1'b0; rx_data <= '0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (!en) begin
        st <= IDLE; cnt <= '0; sda_drv <= 1'b0; m10 <= 1'b0;
      end else if (start) begin
        st <= ADR1; cnt <= '0; sda_drv <= 1'b0;
      end else if (stop) begin
        st <= IDLE; cnt <= '0; sda_drv <= 1'b0; m10 <= 1'b0;
      end else if (st != IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) begin
            if (st != TXD) sh <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            cnt <= 4'd9;
            if (st == TXD) nxt <= sda_s ? IDLE : TXD;
          end
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              ADR1: begin
                sda_drv <= ack1;
                irq     <= ack1 & ~to_adr2;
                nxt     <= !ack1 ? IDLE : rw ? TXD : to_adr2 ? ADR2 : RXD;
              end
              ADR2: begin
                sda_drv <= ack2;
                irq     <= ack2;
                nxt     <= ack2 ? RXD : IDLE;
                if (ack2) m10 <= 1'b1;
              end
              RXD: begin
                sda_drv <= 1'b1; rx_data <= sh; irq <= 1'b1; nxt <= RXD;
              end
              default: sda_drv <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            sda_drv <= 1'b0;
            cnt     <= '0;
            st      <= nxt;
            if (nxt == TXD) irq <= 1'b1;
          end else if (st == TXD && cnt != 4'd0) begin
            sh      <= {sh[6:0], 1'b0};
            sda_drv <= ~sh[6];
          end
        end else if (st == TXD && cnt == 4'd0 && !scl_s) begin
          sh      <= tx_data;
          sda_drv <= ~tx_data[7];
        end
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_slave_chk.sv
module i2c_stretch_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_we,
  input logic [15:0] ctrl_wdata,
  input logic [15:0] ctrl_rdata,
  input logic        scl_oe,
  input logic        sda_oe,
  input logic        irq,
  input logic [3:0]  cnt
);
  a_r1_off_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[0] |=> !sda_oe && !irq);

  a_r3_write_sets_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_rdata[2]) |=> ctrl_rdata[1] == $past(ctrl_wdata[1]));

  a_r4_zero_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_rdata[2] && ctrl_rdata[1]) |=> ctrl_rdata[1]);

  a_r9_irq_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r12_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[0] && scl_oe && $past(scl_oe) && $past(scl_oe, 2) && $past(scl_oe, 3))
      |=> $stable(cnt));
endmodule

bind i2c_stretch_slave i2c_stretch_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .ctrl_rdata(ctrl_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq), .cnt(cnt)
);

// File: tb/sim_i2c_stretch_slave.sv
module sim_i2c_stretch_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [9:0] own_addr = '0;
  logic [7:0] tx_data = '0;
  logic scl_oe, sda_oe, irq;
  logic [15:0] ctrl_rdata;
  logic [7:0] rx_data;
  int checks = 0, fails = 0, irq_cnt = 0;
  logic sda_seen = 1'b0, scl_seen = 1'b0;

  wire scl_line = ~(m_scl_low | scl_oe);
  wire sda_line = ~(m_sda_low | sda_oe);

  always #10 clk = ~clk;

  i2c_stretch_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .own_addr(own_addr), .rx_data(rx_data),
    .tx_data(tx_data), .irq(irq)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (sda_oe) sda_seen = 1'b1;
    if (scl_oe) scl_seen = 1'b1;
  end

  // ctrl(16) own(10) byte(8) ack(1) irq(1)
  localparam logic [35:0] VEC [8] = '{
    {16'h0003, 10'h052, 8'hA4, 1'b1, 1'b1},  // R6 7-bit match
    {16'h0003, 10'h052, 8'hA6, 1'b0, 1'b0},  // R6 mismatch
    {16'h0003, 10'h052, 8'h00, 1'b0, 1'b0},  // R7 general call off
    {16'h0023, 10'h052, 8'h00, 1'b1, 1'b1},  // R7 general call on
    {16'h000B, 10'h052, 8'h3C, 1'b1, 1'b1},  // R5 accept-all
    {16'h0013, 10'h2A5, 8'hF4, 1'b1, 1'b0},  // R6 10-bit header
    {16'h0013, 10'h2A5, 8'hF2, 1'b0, 1'b0},  // R6 wrong high bits
    {16'h0013, 10'h2A5, 8'hF5, 1'b0, 1'b0}   // R6 read header w/o match
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wbit(input logic b);
    cyc(4); m_sda_low = ~b; cyc(6);
    m_scl_low = 1'b0; wait_high; cyc(10);
    m_scl_low = 1'b1;
  endtask

  task automatic rbit(output logic b);
    cyc(4); m_sda_low = 1'b0; cyc(6);
    m_scl_low = 1'b0; wait_high; cyc(5);
    b = sda_line; cyc(5);
    m_scl_low = 1'b1;
  endtask

  task automatic start_c;
    m_sda_low = 1'b1; cyc(10); m_scl_low = 1'b1;
  endtask

  task automatic rstart_c;
    cyc(4); m_sda_low = 1'b0; cyc(6);
    m_scl_low = 1'b0; wait_high; cyc(10);
    m_sda_low = 1'b1; cyc(10); m_scl_low = 1'b1;
  endtask

  task automatic stop_c;
    cyc(4); m_sda_low = 1'b1; cyc(6);
    m_scl_low = 1'b0; wait_high; cyc(10);
    m_sda_low = 1'b0; cyc(10);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~give_ack);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base;
    cyc(3); rst_n = 1'b1; cyc(2);

    check(ctrl_rdata == 16'h0002, "R8 reset value", ctrl_rdata, 16'h0002);
    check(!scl_oe && !sda_oe && !irq, "R2 reset outputs idle", {scl_oe, sda_oe, irq}, 0);

    wr(16'hFE02); cyc(1);
    check(ctrl_rdata == 16'h0002, "R8 unimplemented bits read 0", ctrl_rdata, 16'h0002);
    wr(16'h01C2); cyc(1);
    check(ctrl_rdata == 16'h01C2, "R8 stored-only bits", ctrl_rdata, 16'h01C2);

    // R1 disabled engine ignores a matching address
    wr(16'h0002); own_addr = 10'h052; base = irq_cnt; sda_seen = 1'b0;
    start_c; wbyte(8'hA4, ack); stop_c;
    check(!ack, "R1 no ack when disabled", ack, 0);
    check(irq_cnt == base && !sda_seen, "R1 no drive or irq when disabled", irq_cnt - base, 0);

    foreach (VEC[k]) begin
      wr(VEC[k][35:20]); own_addr = VEC[k][19:10]; base = irq_cnt;
      start_c; wbyte(VEC[k][9:2], ack); stop_c;
      check(ack == VEC[k][1], "R5 R6 R7 address ack", ack, VEC[k][1]);
      check((irq_cnt - base) == int'(VEC[k][0]), "R9 address irq", irq_cnt - base, VEC[k][0]);
    end

    // R10 receive without stretching (R4: no clear on reception)
    wr(16'h0003); own_addr = 10'h052; base = irq_cnt; scl_seen = 1'b0;
    start_c; wbyte(8'hA4, ack); wbyte(8'h5A, ack);
    check(ack && rx_data == 8'h5A, "R10 first byte", rx_data, 8'h5A);
    wbyte(8'hC3, ack);
    check(ack && rx_data == 8'hC3, "R10 second byte", rx_data, 8'hC3);
    stop_c;
    check(irq_cnt - base == 3, "R9 receive irq count", irq_cnt - base, 3);
    check(!scl_seen, "R4 no stretch on reception", scl_seen, 0);

    // R3 automatic stretch after a received byte, R12 count frozen
    wr(16'h0007); base = irq_cnt;
    start_c; wbyte(8'hA4, ack); wbyte(8'h5A, ack); cyc(8);
    check(scl_oe == 1'b1 && ctrl_rdata[1] == 1'b0, "R3 stretch after reception", {scl_oe, ctrl_rdata[1]}, 2'b10);
    cyc(200);
    wr(16'h0007); cyc(2);
    check(!scl_oe, "R2 release ends stretch", scl_oe, 0);
    wbyte(8'h77, ack);
    check(ack && rx_data == 8'h77, "R12 byte after stretch intact", rx_data, 8'h77);
    cyc(8); wr(16'h0007);
    stop_c;

    // R3 / R4 software writes of the release bit
    wr(16'h0005); cyc(2);
    check(scl_oe == 1'b1, "R3 software stretch", scl_oe, 1);
    wr(16'h0007); cyc(2);
    check(!scl_oe, "R3 software release", scl_oe, 0);
    wr(16'h0003); wr(16'h0001); cyc(2);
    check(ctrl_rdata == 16'h0003 && !scl_oe, "R4 written 0 ignored", ctrl_rdata, 16'h0003);

    // R11 transmit, R4 clear at transmit start
    base = irq_cnt;
    start_c; wbyte(8'hA5, ack); cyc(8);
    check(ack, "R6 7-bit read ack", ack, 1);
    check(scl_oe && !ctrl_rdata[1], "R4 clear at transmit start", {scl_oe, ctrl_rdata[1]}, 2'b10);
    check(irq_cnt - base == 2, "R9 match plus request irq", irq_cnt - base, 2);
    tx_data = 8'h96; wr(16'h0003);
    rbyte(1'b1, d);
    check(d == 8'h96, "R11 first transmitted byte", d, 8'h96);
    cyc(8);
    check(scl_oe == 1'b1, "R11 next byte requested", scl_oe, 1);
    tx_data = 8'h3B; wr(16'h0003);
    rbyte(1'b0, d);
    check(d == 8'h3B, "R11 last transmitted byte", d, 8'h3B);
    cyc(8);
    check(!scl_oe && !sda_oe, "R11 nack ends transfer", {scl_oe, sda_oe}, 0);
    stop_c;

    // R6 10-bit write then repeated START read
    wr(16'h0013); own_addr = 10'h2A5; base = irq_cnt;
    start_c; wbyte(8'hF4, ack); wbyte(8'hA5, ack);
    check(ack, "R6 10-bit low byte ack", ack, 1);
    wbyte(8'h11, ack);
    check(ack && rx_data == 8'h11, "R6 10-bit data", rx_data, 8'h11);
    rstart_c; wbyte(8'hF5, ack); cyc(8);
    check(ack, "R6 read after repeated start", ack, 1);
    tx_data = 8'hC7; wr(16'h0013);
    rbyte(1'b0, d);
    check(d == 8'hC7, "R6 10-bit transmit", d, 8'hC7);
    stop_c;
    check(irq_cnt - base == 4, "R9 10-bit irq count", irq_cnt - base, 4);

    base = irq_cnt;
    start_c; wbyte(8'hF4, ack); wbyte(8'hA4, ack); stop_c;
    check(!ack && irq_cnt == base, "R6 wrong low byte refused", ack, 0);

    cyc(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule